// File: doc/BRIEF.md
# Auto-Incrementing LCD Bitmap Store

This block keeps the on/off picture for a multiplexed segment display with four common lines and thirty-two segment lines. The picture is held as sixteen byte-wide entries. Each entry belongs to one common line and covers a group of eight consecutive segments. A serial receiver upstream loads a starting entry address. It then presents display bytes one at a time. Each accepted byte lands in the entry the address points to, and the address then steps to the next entry, so a whole frame can be streamed after a single address load.

On the read side, the display scanner picks a common line and, one clock later, receives all thirty-two segment bits for that line. The upper nibble of one fixed entry is also exported as four general-purpose port bits. These are for a neighbour that reuses the last four segment pins as plain logic outputs. When the display runs with only three commons, the entries of the fourth common are simply unused. The store does nothing special for them.

Top module: `lcdBitmapStore`

## Requirements
- R1: After reset, every stored bit is 0, the entry address is 0000, and `segOut` and `gpPort` read 0.
- R2: The 4-bit entry address has the common index in bits [3:2] (00 = first common line) and the segment group in bits [1:0] (00 = segments 1-8, 11 = segments 25-32). A cycle with `addrLoad` high copies `addrIn` into it.
- R3: A cycle with `dataValid` high and `addrLoad` low stores `dataIn` in the addressed entry, and the address becomes address+1 on the same edge.
- R4: Incrementing from address 1111 yields 0000, and later bytes continue from there.
- R5: `segOut` bit n carries segment n+1. Within the entry for group g, `dataIn` bit 7 maps to `segOut[8g]` and bit 0 maps to `segOut[8g+7]`.
- R6: The value of `comSel` sampled at a clock edge selects the row that appears on `segOut` after that edge. If a byte is written at the same edge, `segOut` shows the contents from before the write.
- R7: `gpPort[0]`..`gpPort[3]` equal bits 7..4 of entry 0011 (first common line, segments 25-32).
- R8: When `addrLoad` and `dataValid` are both high in one cycle, the load takes effect and the byte is discarded. No entry changes.
- R9: In a cycle with `dataValid` and `addrLoad` both low, no entry and no address bit changes, whatever `dataIn` and `addrIn` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrLoad | input | 1 | Load `addrIn` into the entry address |
| addrIn | input | 4 | Start address: common index [3:2], group [1:0] |
| dataValid | input | 1 | Store `dataIn` and advance the address |
| dataIn | input | 8 | Display byte; bit 7 is the lowest segment of its group |
| comSel | input | 2 | Common line the scanner wants to read |
| segOut | output | 32 | Segment bits of the selected line, bit n is segment n+1 |
| gpPort | output | 4 | Port bits taken from entry 0011, bits 7..4 |

## Verification
The bench aims at the wrap from 1111 to 0000. A counter that saturated or stopped there would leave entry 0 unwritten and put the third byte on entry 15. It checks the bit order inside a group, where reversing it would mirror every eight-segment block. It drives a load and a byte in the same cycle: a design that let the byte through would corrupt the old target entry or shift the stream by one. It reads a row in the very cycle that row is written, where write-through would expose the new byte one cycle early. It also checks the port nibble order: a design that swapped it would drive the ports in reverse.

// File: rtl/lcdStorePkg.sv
package lcdStorePkg;
  localparam int NUM_COMS   = 4;
  localparam int NUM_GROUPS = 4;
  localparam int GROUP_BITS = 8;
  localparam int PORT_BITS  = 4;
  localparam int ROW_W      = $clog2(NUM_COMS);
  localparam int GRP_W      = $clog2(NUM_GROUPS);
  localparam int ADDR_W     = ROW_W + GRP_W;
  localparam int ENTRIES    = NUM_COMS * NUM_GROUPS;
  localparam int SEG_COUNT  = NUM_GROUPS * GROUP_BITS;
  // port bits live in the last group of the first common line
  localparam int PORT_ENTRY = NUM_GROUPS - 1;

  typedef struct packed {
    logic             wrEn;
    logic [ROW_W-1:0] wrRow;
    logic [GRP_W-1:0] wrGrp;
  } storeStrb_t;
endpackage

// File: rtl/lcdStoreCtrl.sv
module lcdStoreCtrl
  import lcdStorePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  output storeStrb_t        strb,
  output logic [ADDR_W-1:0] curAddr
);
  logic [ADDR_W-1:0] addrQ;

  // load has priority; a strobe in the same cycle is dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (addrLoad)  addrQ <= addrIn;
    else if (dataValid) addrQ <= addrQ + ADDR_W'(1);
  end

  always_comb begin
    strb.wrEn  = dataValid & ~addrLoad;
    strb.wrRow = addrQ[ADDR_W-1:GRP_W];
    strb.wrGrp = addrQ[GRP_W-1:0];
  end

  assign curAddr = addrQ;
endmodule

// File: rtl/lcdStoreData.sv
module lcdStoreData
  import lcdStorePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  storeStrb_t            strb,
  input  logic [GROUP_BITS-1:0] dataIn,
  input  logic [ROW_W-1:0]      comSel,
  output logic [SEG_COUNT-1:0]  segOut,
  output logic [PORT_BITS-1:0]  gpPort
);
  logic [GROUP_BITS-1:0] mem [ENTRIES];
  logic [SEG_COUNT-1:0]  rowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRIES; k++) mem[k] <= '0;
    end else if (strb.wrEn) begin
      mem[{strb.wrRow, strb.wrGrp}] <= dataIn;
    end
  end

  // registered readout: sees storage before any same-edge write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowQ <= '0;
    else begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int i = 0; i < GROUP_BITS; i++)
          rowQ[g*GROUP_BITS + GROUP_BITS-1-i] <= mem[{comSel, GRP_W'(g)}][i];
    end
  end

  assign segOut = rowQ;

  genvar j;
  generate
    for (j = 0; j < PORT_BITS; j++) begin : gPort
      assign gpPort[j] = mem[PORT_ENTRY][GROUP_BITS-1-j];
    end
  endgenerate
endmodule

// File: rtl/lcdBitmapStore.sv
module lcdBitmapStore
  import lcdStorePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrLoad,
  input  logic [3:0]  addrIn,
  input  logic        dataValid,
  input  logic [7:0]  dataIn,
  input  logic [1:0]  comSel,
  output logic [31:0] segOut,
  output logic [3:0]  gpPort
);
  storeStrb_t        strb;
  logic [ADDR_W-1:0] curAddr;

  lcdStoreCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataValid(dataValid), .strb(strb), .curAddr(curAddr)
  );

  lcdStoreData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .comSel(comSel), .segOut(segOut), .gpPort(gpPort)
  );
endmodule

// File: rtl/lcdBitmapStoreChk.sv
module lcdBitmapStoreChk (
  input logic        clk,
  input logic        rstN,
  input logic        addrLoad,
  input logic [3:0]  addrIn,
  input logic        dataValid,
  input logic [3:0]  curAddr,
  input logic [3:0]  gpPort
);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> curAddr == $past(addrIn));

  // R3 R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrLoad) |=> curAddr == 4'($past(curAddr) + 4'd1));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataValid && !addrLoad) |=> $stable(curAddr));

  // R7
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> $stable(gpPort));

  // R8
  port_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && addrLoad) |=> $stable(gpPort));
endmodule

bind lcdBitmapStore lcdBitmapStoreChk u_chk (
  .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
  .dataValid(dataValid), .curAddr(curAddr), .gpPort(gpPort)
);

// File: tb/lcdBitmapStore_tb.sv
module lcdBitmapStore_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        addrLoad = 0;
  logic [3:0]  addrIn = 0;
  logic        dataValid = 0;
  logic [7:0]  dataIn = 0;
  logic [1:0]  comSel = 0;
  logic [31:0] segOut;
  logic [3:0]  gpPort;

  always #5 clk = ~clk;

  lcdBitmapStore u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataValid(dataValid), .dataIn(dataIn), .comSel(comSel),
    .segOut(segOut), .gpPort(gpPort)
  );

  typedef struct {
    bit          isPort;
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       expQ[$];
  logic [7:0]  model [16];
  logic [3:0]  mAddr;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rowOf(int c);
    logic [31:0] r;
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 8; i++)
        r[g*8 + 7 - i] = model[c*4 + g][i];
    return r;
  endfunction

  // monitor: compare results as they come due
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      act = it.isPort ? {28'd0, gpPort} : segOut;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectRow(int c, string tag);
    item_t it;
    comSel = 2'(c);
    it.isPort = 0; it.due = cyc + 1; it.exp = rowOf(c); it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expectPort(string tag);
    item_t it;
    it.isPort = 1; it.due = cyc + 1;
    it.exp = {28'd0, model[3][4], model[3][5], model[3][6], model[3][7]};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic loadAddr(logic [3:0] a);
    addrLoad = 1; addrIn = a;
    @(negedge clk);
    addrLoad = 0; addrIn = ~a;
    mAddr = a;
  endtask

  task automatic writeByte(logic [7:0] d);
    dataValid = 1; dataIn = d;
    @(negedge clk);
    dataValid = 0; dataIn = ~d;
    model[mAddr] = d;
    mAddr = mAddr + 4'd1;
  endtask

  task automatic readAll(string tag);
    for (int c = 0; c < 4; c++) begin
      expectRow(c, tag);
      idle();
    end
    idle();
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    mAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    idle();

    // R1: cleared store and ports
    expectPort("R1 port reset");
    readAll("R1 reset rows");

    // R2 R3 R5: stream a full frame from 0000
    loadAddr(4'h0);
    for (int k = 0; k < 16; k++) writeByte(8'((k * 37 + 1) ^ (k << 4)));
    readAll("R3 R5 full frame");

    // R5: single-bit pattern shows bit order
    loadAddr(4'h9);
    writeByte(8'h80);
    writeByte(8'h01);
    expectRow(2, "R5 bit order");
    idle(); idle();

    // R4: wrap from 1111 to 0000
    loadAddr(4'hE);
    writeByte(8'h11);
    writeByte(8'h22);
    writeByte(8'h33);
    writeByte(8'h44);
    expectRow(3, "R4 wrap top");
    idle();
    expectRow(0, "R4 wrap bottom");
    idle(); idle();

    // R7: port nibble from entry 0011
    loadAddr(4'h3);
    writeByte(8'hA5);
    expectPort("R7 port A");
    idle();
    loadAddr(4'h3);
    writeByte(8'h3C);
    expectPort("R7 port B");
    idle();

    // R8: load and strobe together, byte dropped
    addrLoad = 1; addrIn = 4'h5; dataValid = 1; dataIn = 8'hFF;
    @(negedge clk);
    addrLoad = 0; dataValid = 0;
    mAddr = 4'h5;
    readAll("R8 collision dropped");
    writeByte(8'h5A);
    expectRow(1, "R8 stream resumes at load");
    idle(); idle();

    // R6: read row 2 in the cycle it is written
    loadAddr(4'hA);
    comSel = 2'd2;
    begin
      item_t it;
      it.isPort = 0; it.due = cyc + 1; it.exp = rowOf(2); it.tag = "R6 old data";
      expQ.push_back(it);
    end
    writeByte(8'hC3);
    expectRow(2, "R6 new data next");
    idle(); idle();

    // R9: busy inputs without strobes change nothing
    for (int k = 0; k < 6; k++) begin
      dataIn = 8'(k * 29); addrIn = 4'(k);
      idle();
    end
    writeByte(8'h77);
    readAll("R9 idle then write");
    expectPort("R9 port unchanged");
    idle(); idle();

    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule